// File: doc/BRIEF.md
# Cascadable Display Register Loader

This block is the write side of a segment display driver that sits on a two-wire I2C bus. It samples SCL and SDA on the system clock and acknowledges writes to the fixed bus address byte 0111 0100. The first byte after the address always loads a control register. Every later byte of the same transfer goes to one of eight 8-bit segment registers.

The control register holds a 6-bit pointer. Its upper three bits name a chip and its lower three bits name a register in that chip. A chip accepts a data byte only when the chip part of the pointer matches its three strap inputs. Every addressed chip advances the pointer after each data byte, whether or not it stored the byte. Several chips that share one bus address therefore keep identical control copies, and one burst fills them one after another.

The outputs are the segment registers, the drive mode and bank bits, and a 32-bit display word built from the bank selected for direct drive.

Top module: `cseg_loader_top`

## Requirements
- R1: Only the address byte 0x74 (7-bit address 0x3A, write) is acknowledged. Any other address byte, including the read form 0x75, gets no acknowledge, and the bytes that follow it change no register.
- R2: In each addressed device, the first byte after the address loads the control register, whatever the strap inputs are. Bit 7 is the mode (0 = direct, 1 = duplex), bit 6 is the bank, and bits 5..0 are the pointer. mode_o and bank_o show bits 7 and 6.
- R3: In direct mode, a data byte is stored in segment register pointer[2:0] when pointer[5:3] equals sub_i[2:0].
- R4: When the subaddress does not match, the data byte is not stored, but it is still acknowledged and the pointer still advances.
- R5: The 6-bit pointer increments by one after every data byte and wraps from 63 to 0. A burst therefore moves from register 7 of subaddress n to register 0 of subaddress n+1.
- R6: In duplex mode, sub_i[2] and pointer bit 5 are ignored. Matching compares pointer[4:3] with sub_i[1:0].
- R7: disp_o byte k (bits 8k+7..8k) shows segment register 2k+bank in direct mode and segment register 2k in duplex mode.
- R8: The device pulls SDA low (sda_pull_o = 1) through the acknowledge clock of the matching address byte and of every data byte that follows it.
- R9: A STOP ends the transfer and leaves every register unchanged. A START or a repeated START makes the next byte after the address a control byte again.
- R10: Reset clears all segment registers and the control register, so disp_o, seg_bytes_o, mode_o and bank_o read zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (wired-AND bus value) |
| sda_pull_o | output | 1 | 1 pulls SDA low for an acknowledge |
| sub_i | input | 3 | Strap subaddress of this device |
| seg_bytes_o | output | 64 | Segment register i at bits 8i+7..8i |
| disp_o | output | 32 | Bank-selected display bytes |
| mode_o | output | 1 | Drive mode bit from control register |
| bank_o | output | 1 | Bank select bit from control register |

## Verification
Assertions check every cycle:
- a control strobe copies the byte into the control register;
- each data strobe steps the pointer by exactly one;
- a strobe that misses the subaddress leaves the segment registers untouched;
- without a strobe, no register moves;
- a STOP releases SDA;
- the acknowledge pull starts only while SCL is low.

Only the bench scenarios can show the rest. These are address filtering, the choice of register under direct and duplex matching, a burst that spills from one chip into a second chip on the same bus, the 63-to-0 wrap, and how repeated START and bare STOP change the role of the next byte.

// File: rtl/cseg_pkg.sv
package cseg_pkg;
    localparam int SEG_W   = 8;
    localparam int NUM_REG = 8;
    localparam int IDX_W   = $clog2(NUM_REG);
    localparam int SUB_W   = 3;
    localparam int VEC_W   = IDX_W + SUB_W;

    typedef enum logic [1:0] {PH_IDLE, PH_RX, PH_ACK, PH_SKIP} phase_e;

    typedef struct packed {
        logic             mode;
        logic             bank;
        logic [VEC_W-1:0] vec;
    } ctrl_t;
endpackage

// File: rtl/cseg_line_filter.sv
module cseg_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          lvl;
        logic          lvl_prev;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d          = q;
        d.sync     = {q.sync[0], line_i};
        d.lvl_prev = q.lvl;
        if (q.sync[1] != q.lvl) begin
            if (q.cnt == CW'(FILT_LEN - 1)) begin
                d.lvl = q.sync[1];
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync     <= 2'b11;
            q.cnt      <= '0;
            q.lvl      <= 1'b1;
            q.lvl_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign level_o = q.lvl;
    assign rise_o  = q.lvl & ~q.lvl_prev;
    assign fall_o  = ~q.lvl & q.lvl_prev;
endmodule

// File: rtl/cseg_i2c_rx.sv
module cseg_i2c_rx
    import cseg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h3A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             sda_rise,
    input  logic             sda_fall,
    output logic             sda_pull_o,
    output logic             wr_stb_o,
    output logic             wr_ctrl_o,
    output logic [SEG_W-1:0] wr_data_o
);
    typedef struct packed {
        phase_e           phase;
        logic [3:0]       bitcnt;
        logic [SEG_W-1:0] shreg;
        logic             addr_ph;
        logic             ctrl_nx;
        logic             pull;
        logic             stb;
        logic             stb_ctrl;
        logic [SEG_W-1:0] data;
    } rx_t;

    rx_t  q, d;
    logic start_det, stop_det;

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (start_det) begin
            d.phase   = PH_RX;
            d.bitcnt  = '0;
            d.addr_ph = 1'b1;
            d.ctrl_nx = 1'b0;
            d.pull    = 1'b0;
        end else if (stop_det) begin
            d.phase = PH_IDLE;
            d.pull  = 1'b0;
        end else begin
            unique case (q.phase)
                PH_RX: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.shreg  = {q.shreg[SEG_W-2:0], sda_lvl};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end
                    if (scl_fall && q.bitcnt == 4'd8) begin
                        if (q.addr_ph) begin
                            if (q.shreg == {DEV_ADDR, 1'b0}) begin
                                d.pull    = 1'b1;
                                d.phase   = PH_ACK;
                                d.addr_ph = 1'b0;
                                d.ctrl_nx = 1'b1;
                            end else begin
                                d.phase = PH_SKIP;
                            end
                        end else begin
                            d.pull     = 1'b1;
                            d.phase    = PH_ACK;
                            d.stb      = 1'b1;
                            d.stb_ctrl = q.ctrl_nx;
                            d.data     = q.shreg;
                            d.ctrl_nx  = 1'b0;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        d.pull   = 1'b0;
                        d.phase  = PH_RX;
                        d.bitcnt = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_pull_o = q.pull;
    assign wr_stb_o   = q.stb;
    assign wr_ctrl_o  = q.stb_ctrl;
    assign wr_data_o  = q.data;

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !q.pull); // R9
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pull) |-> !scl_lvl); // R8
    AST_STB_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |-> q.pull); // R8
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |=> !q.stb); // R5
endmodule

// File: rtl/cseg_reg_file.sv
module cseg_reg_file
    import cseg_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_stb,
    input  logic                              wr_ctrl,
    input  logic [SEG_W-1:0]                  wr_data,
    input  logic [SUB_W-1:0]                  sub_i,
    output ctrl_t                             ctrl_o,
    output logic [NUM_REG-1:0][SEG_W-1:0]     seg_o,
    output logic [NUM_REG/2-1:0][SEG_W-1:0]   disp_o
);
    typedef struct packed {
        ctrl_t                         ctrl;
        logic [NUM_REG-1:0][SEG_W-1:0] seg;
    } rf_t;

    rf_t  q, d;
    logic hit, hit_direct, hit_duplex, sel_odd;

    assign hit_direct = q.ctrl.vec[IDX_W +: SUB_W] == sub_i;
    assign hit_duplex = q.ctrl.vec[IDX_W +: SUB_W-1] == sub_i[SUB_W-2:0];
    assign hit        = q.ctrl.mode ? hit_duplex : hit_direct;

    always_comb begin
        d = q;
        if (wr_stb) begin
            if (wr_ctrl) begin
                d.ctrl = ctrl_t'(wr_data);
            end else begin
                if (hit) d.seg[q.ctrl.vec[IDX_W-1:0]] = wr_data;
                d.ctrl.vec = q.ctrl.vec + VEC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sel_odd = ~q.ctrl.mode & q.ctrl.bank;

    for (genvar k = 0; k < NUM_REG/2; k++) begin : g_disp
        assign disp_o[k] = sel_odd ? q.seg[2*k+1] : q.seg[2*k];
    end

    assign ctrl_o = q.ctrl;
    assign seg_o  = q.seg;

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && wr_ctrl |=> q.ctrl == $past(wr_data)); // R2
    AST_VEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && !wr_ctrl |=> q.ctrl.vec == $past(q.ctrl.vec) + VEC_W'(1)); // R5
    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && !wr_ctrl && !hit |=> $stable(q.seg)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(q.seg) && $stable(q.ctrl)); // R9
endmodule

// File: rtl/cseg_loader_top.sv
module cseg_loader_top
    import cseg_pkg::*;
#(
    parameter int         FILT_LEN = 3,
    parameter logic [6:0] DEV_ADDR = 7'h3A
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_pull_o,
    input  logic [SUB_W-1:0]             sub_i,
    output logic [NUM_REG*SEG_W-1:0]     seg_bytes_o,
    output logic [NUM_REG/2*SEG_W-1:0]   disp_o,
    output logic                         mode_o,
    output logic                         bank_o
);
    logic             scl_lvl, scl_rise, scl_fall;
    logic             sda_lvl, sda_rise, sda_fall;
    logic             wr_stb, wr_ctrl;
    logic [SEG_W-1:0] wr_data;
    ctrl_t            ctrl;
    logic [NUM_REG-1:0][SEG_W-1:0]   seg;
    logic [NUM_REG/2-1:0][SEG_W-1:0] disp;

    cseg_line_filter #(.FILT_LEN(FILT_LEN)) u_scl (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

    cseg_line_filter #(.FILT_LEN(FILT_LEN)) u_sda (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

    cseg_i2c_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .sda_pull_o(sda_pull_o), .wr_stb_o(wr_stb),
        .wr_ctrl_o(wr_ctrl), .wr_data_o(wr_data));

    cseg_reg_file u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
        .sub_i(sub_i), .ctrl_o(ctrl), .seg_o(seg), .disp_o(disp));

    assign seg_bytes_o = seg;
    assign disp_o      = disp;
    assign mode_o      = ctrl.mode;
    assign bank_o      = ctrl.bank;
endmodule

// File: tb/cseg_loader_top_test.sv
module cseg_loader_top_test;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_drv = 1'b1;
    logic [2:0]  sub_a = 3'd0, sub_b = 3'd1;
    logic        pull_a, pull_b, mode_a, mode_b, bank_a, bank_b;
    logic [63:0] seg_a, seg_b;
    logic [31:0] disp_a, disp_b;
    logic        sda_bus;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] mdl_a [8];
    logic [7:0] mdl_b [8];

    assign sda_bus = sda_drv & ~pull_a & ~pull_b;

    always #2 clk = ~clk;

    cseg_loader_top uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_pull_o(pull_a), .sub_i(sub_a), .seg_bytes_o(seg_a),
        .disp_o(disp_a), .mode_o(mode_a), .bank_o(bank_a));

    cseg_loader_top uut_b (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_pull_o(pull_b), .sub_i(sub_b), .seg_bytes_o(seg_b),
        .disp_o(disp_b), .mode_o(mode_b), .bank_o(bank_b));

    // rows: sub[19:17] ctrl[16:9] data[8:1] hit[0]
    localparam logic [19:0] TBL [0:7] = '{
        {3'd0, 8'h00, 8'hA5, 1'b1},
        {3'd0, 8'h05, 8'h3C, 1'b1},
        {3'd3, 8'h1A, 8'h77, 1'b1},
        {3'd3, 8'h22, 8'h11, 1'b0},
        {3'd5, 8'h2F, 8'hE1, 1'b1},
        {3'd6, 8'h91, 8'h5A, 1'b1},
        {3'd6, 8'h99, 8'h66, 1'b0},
        {3'd6, 8'h73, 8'hC3, 1'b1}
    };

    task automatic chk(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pk(input logic [7:0] m [8]);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = m[i];
        return r;
    endfunction

    function automatic logic [31:0] exp_disp(input logic [7:0] m [8],
                                             input logic md, input logic bk);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = m[2*k + ((!md && bk) ? 1 : 0)];
        return r;
    endfunction

    task automatic tick();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick();
        scl = 1'b1;     tick();
        sda_drv = 1'b0; tick();
        scl = 1'b0;     tick();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick();
        scl = 1'b1;     tick();
        sda_drv = 1'b1; tick();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_a, output logic ack_b);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; tick();
            scl = 1'b1;     tick();
            scl = 1'b0;     tick();
        end
        sda_drv = 1'b1; tick();
        scl = 1'b1;     tick();
        ack_a = pull_a;
        ack_b = pull_b;
        scl = 1'b0;     tick();
    endtask

    task automatic clear_models();
        for (int i = 0; i < 8; i++) begin
            mdl_a[i] = 8'h00;
            mdl_b[i] = 8'h00;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a0, a1, a2, a3, a4, b0, b1, b2, b3, b4;
        clear_models();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10: reset state
        chk(seg_a == 64'h0 && disp_a == 32'h0, "R10", seg_a, 64'h0);
        chk({mode_a, bank_a, pull_a} == 3'b000, "R10", {mode_a, bank_a, pull_a}, 0);

        // table walk
        for (int i = 0; i < 8; i++) begin
            logic [19:0] row;
            logic [7:0]  c, dt;
            string       tag;
            row  = TBL[i];
            sub_a = row[19:17];
            c    = row[16:9];
            dt   = row[8:1];
            bus_start();
            send_byte(8'h74, a0, b0);
            send_byte(c, a1, b1);
            send_byte(dt, a2, b2);
            bus_stop();
            if (row[0]) mdl_a[c[2:0]] = dt;
            tag = row[0] ? (c[7] ? "R6" : "R3") : "R4";
            chk(a0 & a1 & a2, "R8", {a0, a1, a2}, 3'b111);
            chk(seg_a == pk(mdl_a) && seg_b == pk(mdl_b), tag, seg_a, pk(mdl_a));
            chk({mode_a, bank_a, mode_b, bank_b} == {c[7:6], c[7:6]}, "R2",
                {mode_a, bank_a, mode_b, bank_b}, {c[7:6], c[7:6]});
            chk(disp_a == exp_disp(mdl_a, c[7], c[6]), "R7", disp_a,
                exp_disp(mdl_a, c[7], c[6]));
        end

        // R1: foreign address and read form are not acknowledged
        bus_start();
        send_byte(8'h76, a0, b0);
        send_byte(8'h00, a1, b1);
        send_byte(8'hFF, a2, b2);
        bus_stop();
        chk(!(a0 | a1 | a2 | b0), "R1", {a0, a1, a2, b0}, 0);
        chk(seg_a == pk(mdl_a) && {mode_a, bank_a} == 2'b01, "R1", seg_a, pk(mdl_a));
        bus_start();
        send_byte(8'h75, a0, b0);
        send_byte(8'h00, a1, b1);
        bus_stop();
        chk(!(a0 | a1), "R1", {a0, a1}, 0);
        chk(seg_a == pk(mdl_a) && {mode_a, bank_a} == 2'b01, "R1", seg_a, pk(mdl_a));

        // R5 / R4: burst spills from uut (sub 0) into uut_b (sub 1)
        sub_a = 3'd0; sub_b = 3'd1;
        bus_start();
        send_byte(8'h74, a0, b0);
        send_byte(8'h06, a1, b1);
        send_byte(8'h10, a2, b2);
        send_byte(8'h20, a3, b3);
        send_byte(8'h30, a4, b4);
        send_byte(8'h40, a4, b4);
        bus_stop();
        mdl_a[6] = 8'h10; mdl_a[7] = 8'h20;
        mdl_b[0] = 8'h30; mdl_b[1] = 8'h40;
        chk(a4 && b1, "R4", {a4, b1}, 2'b11);
        chk(seg_a == pk(mdl_a), "R5", seg_a, pk(mdl_a));
        chk(seg_b == pk(mdl_b), "R5", seg_b, pk(mdl_b));

        // R5: pointer wraps 63 -> 0
        sub_a = 3'd7; sub_b = 3'd0;
        bus_start();
        send_byte(8'h74, a0, b0);
        send_byte(8'h3F, a1, b1);
        send_byte(8'h91, a2, b2);
        send_byte(8'h92, a3, b3);
        bus_stop();
        mdl_a[7] = 8'h91; mdl_b[0] = 8'h92;
        chk(seg_a == pk(mdl_a), "R5", seg_a, pk(mdl_a));
        chk(seg_b == pk(mdl_b), "R5", seg_b, pk(mdl_b));

        // R9: repeated START turns the next byte into control again
        sub_a = 3'd0; sub_b = 3'd1;
        bus_start();
        send_byte(8'h74, a0, b0);
        send_byte(8'h00, a1, b1);
        send_byte(8'h44, a2, b2);
        bus_start();
        send_byte(8'h74, a3, b3);
        send_byte(8'h42, a4, b4);
        send_byte(8'h55, a4, b4);
        bus_stop();
        mdl_a[0] = 8'h44; mdl_a[2] = 8'h55;
        chk(seg_a == pk(mdl_a), "R9", seg_a, pk(mdl_a));
        chk({mode_a, bank_a} == 2'b01 && a3, "R9", {mode_a, bank_a, a3}, 3'b011);

        // R9: bare STOP changes nothing, next transfer starts with control
        bus_start();
        send_byte(8'h74, a0, b0);
        bus_stop();
        chk(seg_a == pk(mdl_a) && {mode_a, bank_a} == 2'b01, "R9", seg_a, pk(mdl_a));
        bus_start();
        send_byte(8'h74, a0, b0);
        send_byte(8'h04, a1, b1);
        send_byte(8'h66, a2, b2);
        bus_stop();
        mdl_a[4] = 8'h66;
        chk(seg_a == pk(mdl_a) && {mode_a, bank_a} == 2'b00, "R9", seg_a, pk(mdl_a));
        chk(disp_a == exp_disp(mdl_a, 1'b0, 1'b0), "R7", disp_a, exp_disp(mdl_a, 1'b0, 1'b0));

        // R10: reset blanks loaded registers
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(seg_a == 64'h0 && seg_b == 64'h0, "R10", seg_a, 64'h0);
        chk(disp_a == 32'h0 && {mode_a, bank_a, pull_a} == 3'b000, "R10", disp_a, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule